// File: doc/BRIEF.md
# Host Memory Write Port with Two-Cycle Wide Words

This block is a slave port through which an external host fills the on-chip program and data memories over one shared 16-bit address/data bus. The host first runs an address-latch cycle that picks a memory space and a start address. It then issues write strobes, and the port steps the address by one after each complete word. A data-memory word is 16 bits and takes one host cycle.

A program-memory word is 24 bits and takes two host cycles. The first cycle is parked in a holding register and is acknowledged at once. The second cycle completes the word and starts the internal memory write. During that write the acknowledge is held low until the port can accept the next transaction. An address-latch cycle, or a core write to the port's control register, discards a first half that is still waiting. The next program-memory write then counts as a new first half.

The block also implements the boot hold-off. The map and boot-mode inputs are sampled while reset is asserted. If they select port booting, the core is held until a complete program-memory word lands at address zero.

Top module: `hdma_wr_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `host_ack` is 1, `pm_we`, `dm_we` and `boot_released` are 0, and the latched address is 0 in program space.
- R2: A cycle with `host_latch`=1 that is accepted loads the memory space from bus bit 15 (0 = program, 1 = data) and the start address from bus bits ADDR_W-1:0. It also discards any waiting first half.
- R3: An accepted data-memory write strobe at clock T drives `dm_we`=1, with `mem_addr` set to the current address and `mem_wdata`={8'h00, bus}. These hold stable in cycles T+1 to T+WR_CYCLES, and `host_ack` is 0 in those cycles and 1 from cycle T+WR_CYCLES+1.
- R4: A program-memory write strobe with no first half waiting stores the bus in the holding register. `host_ack` stays 1 and no memory write is started.
- R5: A program-memory write strobe with a first half waiting writes {held[15:0], bus[7:0]} to program memory. It uses the same cycle timing as R3, with `pm_we` in place of `dm_we`.
- R6: The address steps by one, modulo 2^ADDR_W, when each complete word's memory write finishes.
- R7: `core_ctrl_wr`=1 discards a waiting first half. A write strobe in the same cycle is then handled as a first half.
- R8: While `host_ack` is 0, the latch and write strobes are ignored: no address change and no memory write.
- R9: If `map_sel`=0 and `boot_sel`=1 during reset, `core_hold` is 1 until a program-memory word at address 0 finishes writing. It falls in the cycle `host_ack` rises. Any other input pair gives `core_hold`=0.
- R10: `boot_released` sets when a program-memory word at address 0 finishes writing, in either mode, and stays set until reset. A data-memory word at address 0 does not set it.
- R11: When `host_latch` and `host_wsel` are both 1 in an accepted cycle, the latch is taken and the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_bus | input | 16 | Shared host address/data bus |
| host_latch | input | 1 | Address-latch strobe |
| host_wsel | input | 1 | Write strobe |
| core_ctrl_wr | input | 1 | Core write to the port control register |
| map_sel | input | 1 | Memory-map select, sampled during reset |
| boot_sel | input | 1 | Boot-mode select, sampled during reset |
| host_ack | output | 1 | Acknowledge / ready to the host |
| pm_we | output | 1 | Program-memory write enable |
| dm_we | output | 1 | Data-memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 24 | Memory write data (data memory uses bits 15:0) |
| core_hold | output | 1 | Core execution held off |
| boot_released | output | 1 | Sticky flag: program word at address 0 was written |

## Verification
The hardest state to reach is a waiting first half that is killed between the two halves. It can be killed by a fresh latch or by a control write, and the control write may land in the same cycle as a write strobe. The stimulus parks a first half, then fires each kind of discard, and then sends two more halves. The reference model shows which bus value ends up in the upper 16 bits. Strobes fired deliberately while the acknowledge is low test that the busy window is closed. A program word at address zero in boot mode, followed by a second one, tests the release and that the flag stays set.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

    localparam int BUS_W  = 16;
    localparam int LOW_W  = 8;
    localparam int WORD_W = BUS_W + LOW_W;
    localparam int SPACE_BIT = BUS_W - 1;

    typedef enum logic {
        SPACE_PM = 1'b0,
        SPACE_DM = 1'b1
    } space_e;

    typedef struct packed {
        space_e              space;
        logic [WORD_W-1:0]   data;
    } wr_word_t;

    function automatic logic [WORD_W-1:0] join_pm(input logic [BUS_W-1:0] upper,
                                                  input logic [BUS_W-1:0] bus);
        return {upper, bus[LOW_W-1:0]};
    endfunction

    function automatic logic [WORD_W-1:0] widen_dm(input logic [BUS_W-1:0] bus);
        return {{LOW_W{1'b0}}, bus};
    endfunction

endpackage

// File: rtl/hdma_addr_reg.sv
module hdma_addr_reg
    import hdma_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [BUS_W-1:0]     load_bus,
    input  logic                 bump,
    output logic [ADDR_W-1:0]    addr,
    output space_e               space
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            space <= SPACE_PM;
        end else if (load) begin
            addr  <= load_bus[ADDR_W-1:0];
            space <= space_e'(load_bus[SPACE_BIT]);
        end else if (bump) begin
            addr  <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/hdma_word_asm.sv
module hdma_word_asm
    import hdma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_take,
    input  logic                 discard,
    input  space_e               space,
    input  logic [BUS_W-1:0]     bus,
    output logic                 go,
    output wr_word_t             word,
    output logic                 pending
);

    logic [BUS_W-1:0] hold_q;
    logic             pend_eff;

    assign pend_eff = pending & ~discard;

    always_comb begin
        go         = wr_take & ((space == SPACE_DM) | pend_eff);
        word.space = space;
        word.data  = (space == SPACE_DM) ? widen_dm(bus) : join_pm(hold_q, bus);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            hold_q  <= '0;
        end else if (wr_take && space == SPACE_PM) begin
            pending <= ~pend_eff;
            if (!pend_eff) begin
                hold_q <= bus;
            end
        end else if (discard) begin
            pending <= 1'b0;
        end
    end

    // R7: a discard leaves no first half waiting unless a new one is taken
    assert_discard_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (discard && !(wr_take && space == SPACE_PM)) |=> !pending);

endmodule

// File: rtl/hdma_wr_engine.sv
module hdma_wr_engine
    import hdma_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int WR_CYCLES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  wr_word_t             word,
    input  logic [ADDR_W-1:0]    addr_in,
    output logic                 busy,
    output logic                 fin,
    output logic                 ack,
    output logic                 pm_we,
    output logic                 dm_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    output space_e               mem_space
);

    localparam int CW = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES);
    localparam logic [CW-1:0] LOAD_VAL = CW'(WR_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign fin   = busy & (cnt == '0);
    assign pm_we = busy & (mem_space == SPACE_PM);
    assign dm_we = busy & (mem_space == SPACE_DM);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            ack       <= 1'b1;
            cnt       <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_space <= SPACE_PM;
        end else if (go) begin
            busy      <= 1'b1;
            ack       <= 1'b0;
            cnt       <= LOAD_VAL;
            mem_addr  <= addr_in;
            mem_wdata <= word.data;
            mem_space <= word.space;
        end else if (fin) begin
            busy      <= 1'b0;
            ack       <= 1'b1;
        end else if (busy) begin
            cnt       <= cnt - 1'b1;
        end
    end

    // R3: a started word pulls the acknowledge low on the next clock
    assert_ack_drop_R3: assert property (@(posedge clk) disable iff (rst)
        go |=> !ack);

    // R5: the acknowledge returns one clock after the write completes
    assert_ack_rise_R5: assert property (@(posedge clk) disable iff (rst)
        fin |=> ack);

    // R3: address and data hold still through the write window
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(fin)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    // R8: no new word may start while one is being written
    assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);

    // R3: acknowledge and busy window agree
    assert_ack_busy_R3: assert property (@(posedge clk) disable iff (rst)
        ack == !busy);

endmodule

// File: rtl/hdma_boot_ctl.sv
module hdma_boot_ctl (
    input  logic clk,
    input  logic rst,
    input  logic map_sel,
    input  logic boot_sel,
    input  logic zero_done,
    output logic core_hold,
    output logic released
);

    logic boot_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_mode <= ~map_sel & boot_sel;
            released  <= 1'b0;
        end else if (zero_done) begin
            released  <= 1'b1;
        end
    end

    assign core_hold = boot_mode & ~released;

    // R10: the release flag never clears outside reset
    assert_release_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        released |=> released);

    // R9: the core is only let go by a release
    assert_hold_ends_by_release_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(core_hold) |-> released);

    // R9: boot mode is frozen once reset ends
    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        $stable(boot_mode));

endmodule

// File: rtl/hdma_wr_port.sv
module hdma_wr_port
    import hdma_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int WR_CYCLES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [15:0]          host_bus,
    input  logic                 host_latch,
    input  logic                 host_wsel,
    input  logic                 core_ctrl_wr,
    input  logic                 map_sel,
    input  logic                 boot_sel,
    output logic                 host_ack,
    output logic                 pm_we,
    output logic                 dm_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [23:0]          mem_wdata,
    output logic                 core_hold,
    output logic                 boot_released
);

    logic              busy;
    logic              fin;
    logic              go;
    logic              pending;
    logic              latch_take;
    logic              wr_take;
    logic              discard;
    logic              zero_done;
    logic [ADDR_W-1:0] cur_addr;
    space_e            cur_space;
    space_e            mem_space;
    wr_word_t          word;

    assign latch_take = host_latch & ~busy;
    assign wr_take    = host_wsel & ~busy & ~host_latch;
    assign discard    = latch_take | core_ctrl_wr;
    assign zero_done  = fin & (mem_space == SPACE_PM) & (mem_addr == '0);

    hdma_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (latch_take),
        .load_bus (host_bus),
        .bump     (fin),
        .addr     (cur_addr),
        .space    (cur_space)
    );

    hdma_word_asm u_asm (
        .clk      (clk),
        .rst      (rst),
        .wr_take  (wr_take),
        .discard  (discard),
        .space    (cur_space),
        .bus      (host_bus),
        .go       (go),
        .word     (word),
        .pending  (pending)
    );

    hdma_wr_engine #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .word      (word),
        .addr_in   (cur_addr),
        .busy      (busy),
        .fin       (fin),
        .ack       (host_ack),
        .pm_we     (pm_we),
        .dm_we     (dm_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_space (mem_space)
    );

    hdma_boot_ctl u_boot (
        .clk       (clk),
        .rst       (rst),
        .map_sel   (map_sel),
        .boot_sel  (boot_sel),
        .zero_done (zero_done),
        .core_hold (core_hold),
        .released  (boot_released)
    );

    // R4: a first half is acknowledged at once and left waiting
    assert_first_half_acks_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_take && cur_space == SPACE_PM && !pending && !core_ctrl_wr) |=> (host_ack && pending && !pm_we));

    // R8: strobes during a write do not move the address
    assert_busy_addr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !fin) |=> $stable(cur_addr));

    // R6: completion of a word advances the address by one
    assert_step_after_word_R6: assert property (@(posedge clk) disable iff (rst)
        fin |=> (cur_addr == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

// File: tb/hdma_wr_port_test.sv
module hdma_wr_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int WRC = 3;
    localparam int AW = 14;
    localparam int AMASK = (1 << AW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_bus = '0;
    logic        host_latch = 1'b0;
    logic        host_wsel = 1'b0;
    logic        core_ctrl_wr = 1'b0;
    logic        map_sel = 1'b0;
    logic        boot_sel = 1'b1;
    logic        host_ack;
    logic        pm_we;
    logic        dm_we;
    logic [AW-1:0] mem_addr;
    logic [23:0] mem_wdata;
    logic        core_hold;
    logic        boot_released;

    hdma_wr_port #(.ADDR_W(AW), .WR_CYCLES(WRC)) uut (
        .clk(clk), .rst(rst), .host_bus(host_bus), .host_latch(host_latch),
        .host_wsel(host_wsel), .core_ctrl_wr(core_ctrl_wr), .map_sel(map_sel),
        .boot_sel(boot_sel), .host_ack(host_ack), .pm_we(pm_we), .dm_we(dm_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .core_hold(core_hold),
        .boot_released(boot_released)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // behavioural reference state
    int          m_left = 0;
    bit          m_pend = 0;
    logic [15:0] m_hold = '0;
    int          m_addr = 0;
    bit          m_space = 0;
    int          m_waddr = 0;
    logic [23:0] m_wdata = '0;
    bit          m_wspace = 0;
    bit          m_rel = 0;
    bit          m_bootm = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_bootm = !map_sel && boot_sel;
            m_left = 0; m_pend = 0; m_addr = 0; m_space = 0; m_rel = 0;
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
                if (!m_wspace && m_waddr == 0) m_rel = 1;
                m_addr = (m_addr + 1) & AMASK;
            end
            if (core_ctrl_wr) m_pend = 0;
        end else if (host_latch) begin
            m_space = host_bus[15];
            m_addr = int'(host_bus) & AMASK;
            m_pend = 0;
        end else begin
            if (core_ctrl_wr) m_pend = 0;
            if (host_wsel) begin
                if (m_space) begin
                    m_left = WRC; m_waddr = m_addr; m_wspace = 1;
                    m_wdata = {8'h00, host_bus};
                end else if (!m_pend) begin
                    m_hold = host_bus; m_pend = 1;
                end else begin
                    m_left = WRC; m_waddr = m_addr; m_wspace = 0;
                    m_wdata = {m_hold, host_bus[7:0]}; m_pend = 0;
                end
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("host_ack", 32'(host_ack), 32'(m_left == 0));
            chk("pm_we", 32'(pm_we), 32'(m_left > 0 && !m_wspace));
            chk("dm_we", 32'(dm_we), 32'(m_left > 0 && m_wspace));
            chk("core_hold", 32'(core_hold), 32'(m_bootm && !m_rel));
            chk("boot_released", 32'(boot_released), 32'(m_rel));
            if (m_left > 0) begin
                chk("mem_addr", 32'(mem_addr), 32'(m_waddr));
                chk("mem_wdata", 32'(mem_wdata), 32'(m_wdata));
            end
        end
    end

    task automatic cyc(input bit l, input bit w, input bit c, input logic [15:0] b);
        @(negedge clk); #1;
        host_latch = l; host_wsel = w; core_ctrl_wr = c; host_bus = b;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 16'h0000);
    endtask

    task automatic wait_ack();
        idle();
        while (!host_ack) idle();
    endtask

    task automatic latch(input bit dm, input int a);
        cyc(1, 0, 0, {dm, 1'b0, 14'(a)});
        idle();
    endtask

    task automatic wr(input logic [15:0] d);
        cyc(0, 1, 0, d);
        wait_ack();
    endtask

    task automatic do_reset(input bit ms, input bit bs);
        @(negedge clk); #1;
        rst = 1; map_sel = ms; boot_sel = bs;
        host_latch = 0; host_wsel = 0; core_ctrl_wr = 0;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk); #2;
        cur_req = "R1";
        chk("R1 ack after reset", 32'(host_ack), 32'd1);
        chk("R1 pm_we after reset", 32'(pm_we), 32'd0);
        chk("R1 dm_we after reset", 32'(dm_we), 32'd0);
        chk("R1 released after reset", 32'(boot_released), 32'd0);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset(0, 1);
        cur_req = "R9";
        chk("R9 hold in boot mode", 32'(core_hold), 32'd1);

        cur_req = "R2"; latch(1, 16'h0005);
        cur_req = "R3"; wr(16'hA1B2); wr(16'h0C0D);
        cur_req = "R6"; wr(16'hFFFF);

        cur_req = "R10"; latch(1, 0); wr(16'h1234);
        chk("R10 data addr 0 no release", 32'(boot_released), 32'd0);

        cur_req = "R4"; latch(0, 16'h0010);
        cyc(0, 1, 0, 16'hBEEF); idle();
        chk("R4 ack after first half", 32'(host_ack), 32'd1);
        chk("R4 no pm write", 32'(pm_we), 32'd0);
        cur_req = "R5"; wr(16'h5A77);
        cur_req = "R4"; wr(16'hCAFE);
        cur_req = "R5"; wr(16'h0042);

        cur_req = "R7"; latch(0, 16'h0020);
        wr(16'h1111); latch(0, 16'h0020);
        wr(16'h2222); wr(16'h0033);
        wr(16'h4444); cyc(0, 0, 1, 16'h0); idle();
        wr(16'h5555); wr(16'h0066);
        wr(16'h7777); cyc(0, 1, 1, 16'h8888); idle();
        wr(16'h0099);

        cur_req = "R8"; latch(1, 16'h0100);
        cyc(0, 1, 0, 16'hAAAA);
        cyc(0, 1, 0, 16'hBBBB);
        cyc(1, 0, 0, 16'h8300);
        wait_ack();
        wr(16'hCCCC);

        cur_req = "R11"; cyc(1, 1, 0, 16'h8200); idle();
        wr(16'hDDDD);

        cur_req = "R6"; latch(1, AMASK);
        wr(16'h0001); wr(16'h0002);

        cur_req = "R9"; latch(0, 0);
        wr(16'hABCD);
        chk("R9 still held after first half", 32'(core_hold), 32'd1);
        wr(16'h00EF);
        chk("R9 released after pm 0", 32'(core_hold), 32'd0);
        cur_req = "R10"; latch(0, 0);
        wr(16'h0101); wr(16'h0202);
        chk("R10 release sticky", 32'(boot_released), 32'd1);

        do_reset(1, 1);
        cur_req = "R9";
        chk("R9 no hold when map set", 32'(core_hold), 32'd0);
        latch(0, 0); wr(16'h3333); wr(16'h0044);
        cur_req = "R10";
        chk("R10 release in normal mode", 32'(boot_released), 32'd1);

        repeat (3) idle();
        finish_run();
    end

endmodule